// File: doc/BRIEF.md
# Serial Line Auto-Baud Detector

This block finds the bit period of an incoming asynchronous serial line. Software arms it with a start pulse and a window select, then has the remote side send a known calibration byte. The block waits for the first falling edge on the line, which is the start bit. It counts module clocks until the first rising edge, then divides the count by the number of bit times the chosen byte holds low. The result is the bit period in module clocks, ready to load into a baud generator.

The block drops its busy state by itself when the measurement ends. If the line stays low past the counter's range, the block raises a timeout flag and does not raise the done flag. Both flags stay set until software clears them with a write-1 pulse. An interrupt request is raised while either flag is set and interrupts are enabled.

Top module: `baud_autodetect`

## Requirements
- R1: The line input passes through a two-flop synchronizer. The measured count equals the number of module clocks during which the line is low, down to a single clock.
- R2: `win_sel_i` selects how many bit times the low phase spans: 0 is 1 bit (calibration byte 0x01), 1 is 2 bits (0x02), 2 is 4 bits (0x08), 3 is 8 bits (0x80). The start bit is included in this count. The divisor equals the low count shifted right by `win_sel_i`, truncated. The select is sampled at the start pulse.
- R3: Counting starts only at the first falling edge after the start pulse. A line that is already low at arming, and the rising edge that follows, are ignored.
- R4: `busy_o` rises the cycle after a start pulse given while idle. It clears by itself when the measurement finishes or times out.
- R5: On a rising edge during counting, `divisor_o` updates and `done_o` sets on the same clock edge.
- R6: If the count reaches 65535 with no rising edge, `tout_o` sets, `done_o` does not set, and `divisor_o` keeps its previous value.
- R7: A pulse on `clr_done_i` clears `done_o`, and a pulse on `clr_tout_i` clears `tout_o`. Each clear leaves the other flag untouched. If a flag is set and cleared in the same cycle, the set takes effect.
- R8: `irq_o` is high exactly while `irq_en_i` is high and at least one of `done_o` and `tout_o` is set.
- R9: After reset, `divisor_o` is 0 and `busy_o`, `done_o`, `tout_o` and `irq_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, asynchronous, idle high |
| start_i | input | 1 | One-cycle pulse that arms a measurement |
| win_sel_i | input | 2 | Window select: the number of bit times held low is 2^sel |
| irq_en_i | input | 1 | Interrupt enable |
| clr_done_i | input | 1 | Write-1 pulse that clears the done flag |
| clr_tout_i | input | 1 | Write-1 pulse that clears the timeout flag |
| divisor_o | output | 16 | Measured bit period in module clocks |
| busy_o | output | 1 | Measurement armed or in progress |
| done_o | output | 1 | Measurement finished flag |
| tout_o | output | 1 | Counter overflow flag |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The measurement is tried with low phases that divide exactly by every window size. These patterns show that each select value applies its own shift. Low phases that leave a remainder show that the result is truncated rather than rounded. Single-clock and very short pulses show that the synchronizer neither stretches nor drops a low phase. A line held low at arming shows that the pre-existing level is ignored, and a low phase past the counter range tells the timeout path apart from a normal finish.

// File: rtl/abd_pkg.sv
package abd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_MEAS = 2'd2
  } abd_state_e;
endpackage

// File: rtl/abd_rx_edge.sv
module abd_rx_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic fall_o,
  output logic rise_o
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q[i] <= 1'b1;
        else if (i == 0) sync_q[i] <= rx_i;
        else sync_q[i] <= sync_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync_q[LAST];
  end

  assign fall_o = prev_q & ~sync_q[LAST];
  assign rise_o = ~prev_q & sync_q[LAST];
endmodule

// File: rtl/abd_meas.sv
module abd_meas
  import abd_pkg::*;
#(
  parameter int unsigned CNT_W = 16,
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SEL_W-1:0] win_sel_i,
  input  logic             fall_i,
  input  logic             rise_i,
  output logic [CNT_W-1:0] div_o,
  output logic             busy_o,
  output logic             fin_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  abd_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] div_q;
  logic [SEL_W-1:0] sel_q;
  logic             in_meas;

  assign in_meas = (state_q == ST_MEAS);
  assign fin_o   = in_meas & rise_i;
  assign ovf_o   = in_meas & ~rise_i & (cnt_q == CNT_MAX);
  assign busy_o  = (state_q != ST_IDLE);
  assign div_o   = div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      div_q   <= '0;
      sel_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q <= ST_ARM;
          sel_q   <= win_sel_i;
        end
        ST_ARM: if (fall_i) begin
          state_q <= ST_MEAS;
          cnt_q   <= CNT_W'(1);
        end
        ST_MEAS: begin
          if (rise_i) begin
            div_q   <= cnt_q >> sel_q;  // divide by 2^sel bit times
            state_q <= ST_IDLE;
          end else if (cnt_q == CNT_MAX) begin
            state_q <= ST_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/abd_flags.sv
module abd_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fin_i,
  input  logic ovf_i,
  input  logic clr_done_i,
  input  logic clr_tout_i,
  input  logic irq_en_i,
  output logic done_o,
  output logic tout_o,
  output logic irq_o
);
  logic done_q, tout_q;

  // set wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      tout_q <= 1'b0;
    end else begin
      if (fin_i)           done_q <= 1'b1;
      else if (clr_done_i) done_q <= 1'b0;
      if (ovf_i)           tout_q <= 1'b1;
      else if (clr_tout_i) tout_q <= 1'b0;
    end
  end

  assign done_o = done_q;
  assign tout_o = tout_q;
  assign irq_o  = irq_en_i & (done_q | tout_q);
endmodule

// File: rtl/baud_autodetect.sv
module baud_autodetect #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SEL_W       = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_i,
  input  logic             start_i,
  input  logic [SEL_W-1:0] win_sel_i,
  input  logic             irq_en_i,
  input  logic             clr_done_i,
  input  logic             clr_tout_i,
  output logic [CNT_W-1:0] divisor_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             tout_o,
  output logic             irq_o
);
  logic fall, rise, fin, ovf;

  abd_rx_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rx_i   (rx_i),
    .fall_o (fall),
    .rise_o (rise)
  );

  abd_meas #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_meas (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .win_sel_i (win_sel_i),
    .fall_i    (fall),
    .rise_i    (rise),
    .div_o     (divisor_o),
    .busy_o    (busy_o),
    .fin_o     (fin),
    .ovf_o     (ovf)
  );

  abd_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .fin_i      (fin),
    .ovf_i      (ovf),
    .clr_done_i (clr_done_i),
    .clr_tout_i (clr_tout_i),
    .irq_en_i   (irq_en_i),
    .done_o     (done_o),
    .tout_o     (tout_o),
    .irq_o      (irq_o)
  );
endmodule

// File: rtl/baud_autodetect_chk.sv
module baud_autodetect_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             irq_en_i,
  input logic             clr_done_i,
  input logic [CNT_W-1:0] divisor_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             tout_o,
  input logic             irq_o
);
  AST_START_ARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R4

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $fell(busy_o)); // R5

  AST_TOUT_ENDS_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tout_o) |-> $fell(busy_o)); // R6

  AST_DIV_ON_FINISH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(divisor_o) |-> (done_o && $fell(busy_o))); // R5

  AST_CLEAR_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_done_i |=> (!done_o || $fell(busy_o))); // R7

  AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !irq_en_i |-> !irq_o); // R8

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (done_o || tout_o)); // R8
endmodule

bind baud_autodetect baud_autodetect_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .irq_en_i   (irq_en_i),
  .clr_done_i (clr_done_i),
  .divisor_o  (divisor_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .tout_o     (tout_o),
  .irq_o      (irq_o)
);

// File: tb/baud_autodetect_bench.sv
`timescale 1ns/1ps
module baud_autodetect_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        rx_i = 1'b1;
  logic        start_i = 1'b0;
  logic [1:0]  win_sel_i = 2'd0;
  logic        irq_en_i = 1'b1;
  logic        clr_done_i = 1'b0;
  logic        clr_tout_i = 1'b0;
  logic [15:0] divisor_o;
  logic        busy_o, done_o, tout_o, irq_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #5 clk_i = ~clk_i;

  baud_autodetect u_baud_autodetect (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(rx_i), .start_i(start_i),
    .win_sel_i(win_sel_i), .irq_en_i(irq_en_i), .clr_done_i(clr_done_i),
    .clr_tout_i(clr_tout_i), .divisor_o(divisor_o), .busy_o(busy_o),
    .done_o(done_o), .tout_o(tout_o), .irq_o(irq_o)
  );

  // {select, low clocks, expected divisor}
  localparam int unsigned NVEC = 9;
  localparam int unsigned VEC [NVEC][3] = '{
    '{0, 40, 40}, '{1, 80, 40}, '{2, 160, 40}, '{3, 320, 40},
    '{3, 327, 40}, '{2, 7, 1}, '{0, 1, 1}, '{1, 3, 1}, '{3, 1000, 125}
  };

  task automatic chk(input string req, input int unsigned act, input int unsigned exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic arm(input logic [1:0] sel);
    win_sel_i = sel;
    start_i = 1'b1;
    cyc(1);
    start_i = 1'b0;
  endtask

  task automatic low_pulse(input int len);
    rx_i = 1'b0;
    cyc(len);
    rx_i = 1'b1;
    cyc(6);
  endtask

  task automatic pulse_clr(input bit d, input bit t);
    clr_done_i = d;
    clr_tout_i = t;
    cyc(1);
    clr_done_i = 1'b0;
    clr_tout_i = 1'b0;
    cyc(1);
  endtask

  initial begin
    cyc(3);
    chk("R9 divisor", divisor_o, 0);
    chk("R9 busy", busy_o, 0);
    chk("R9 flags", {done_o, tout_o, irq_o}, 0);
    rst_ni = 1'b1;
    cyc(3);

    for (int i = 0; i < NVEC; i++) begin
      arm(2'(VEC[i][0]));
      chk("R4 busy after start", busy_o, 1);
      cyc(3);
      low_pulse(int'(VEC[i][1]));
      chk($sformatf("R2 R1 divisor vec %0d", i), divisor_o, VEC[i][2]);
      chk("R4 busy self-clears", busy_o, 0);
      chk("R5 done set", done_o, 1);
      chk("R8 irq with done", irq_o, 1);
      pulse_clr(1'b1, 1'b0);
      chk("R7 done cleared", done_o, 0);
    end

    // line low at arming: that level and its release are ignored
    rx_i = 1'b0;
    cyc(5);
    arm(2'd0);
    cyc(50);
    rx_i = 1'b1;
    cyc(6);
    chk("R3 still armed", busy_o, 1);
    chk("R3 no done", done_o, 0);
    low_pulse(24);
    chk("R3 divisor from later edge", divisor_o, 24);
    pulse_clr(1'b1, 1'b0);

    // irq gating
    irq_en_i = 1'b0;
    arm(2'd1);
    cyc(3);
    low_pulse(60);
    chk("R5 divisor", divisor_o, 30);
    chk("R8 irq masked", irq_o, 0);
    irq_en_i = 1'b1;
    cyc(1);
    chk("R8 irq unmasked", irq_o, 1);

    // timeout with done still set
    arm(2'd0);
    cyc(3);
    rx_i = 1'b0;
    cyc(65540);
    chk("R6 tout set", tout_o, 1);
    chk("R6 busy cleared", busy_o, 0);
    rx_i = 1'b1;
    cyc(6);
    chk("R6 divisor kept", divisor_o, 30);
    chk("R6 tout stays", tout_o, 1);
    pulse_clr(1'b1, 1'b0);
    chk("R7 done cleared", done_o, 0);
    chk("R7 tout untouched", tout_o, 1);
    chk("R8 irq from tout", irq_o, 1);
    pulse_clr(1'b0, 1'b1);
    chk("R7 tout cleared", tout_o, 0);
    chk("R8 irq drops", irq_o, 0);

    // timeout alone does not set done
    arm(2'd2);
    cyc(3);
    rx_i = 1'b0;
    cyc(65540);
    rx_i = 1'b1;
    cyc(6);
    chk("R6 no done on timeout", done_o, 0);
    chk("R6 tout again", tout_o, 1);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule